// File: doc/BRIEF.md
# Multiplexed Bidirectional Bus Latch

This block joins a single A port to two B banks, bank 1 and bank 2, all of the same width (12 bits by default). Towards the banks, the A value is fed into two separate storage slots, one per bank. Each bank has its own active-low drive enable, so one A stream can be split into address and data, or spread across interleaved memory banks. Towards A, each bank input has its own storage slot. A select input picks which of the two slots drives A, and A has its own active-low drive enable.

All four slots behave as level-sensitive latches. While a slot's open control is high, its output shows its input directly. While the control is low, the output shows the value stored at the last rising clock edge at which the control was high. Every port is modelled as a data value plus a drive-enable bit instead of a tri-state net. A port that is not driven shows zero on its data output. A synchronous reset clears all four slots to zero.

Top module: `mbl_top`

## Requirements
- R1: While `open_b1a_i` is high, `pick_bank1_i` is high and `en_a_n_i` is low, `port_a_o` equals the live `bank1_i` in the same cycle. The same holds for `open_b2a_i` with `pick_bank1_i` low and `bank2_i`.
- R2: While the open control of the selected bank-to-A slot is low, `port_a_o` shows the bank input that was present at the last rising edge at which that control was high. Input changes made while the control is low do not reach `port_a_o`.
- R3: `pick_bank1_i` = 1 routes the bank 1 slot to A, and `pick_bank1_i` = 0 routes the bank 2 slot to A.
- R4: While `en_a_n_i` is high, `port_a_en_o` is 0 and `port_a_o` is all zeros, whatever the select and slot states. While it is low, `port_a_en_o` is 1.
- R5: `en_b1_n_i` and `en_b2_n_i` are independent and active low. A bank whose enable is high shows drive-enable 0 and data zero. A bank whose enable is low shows drive-enable 1.
- R6: With `open_a2b1_i` and `open_a2b2_i` both high, both enabled banks show the live `port_a_i` in the same cycle.
- R7: With exactly one of `open_a2b1_i` / `open_a2b2_i` low, that bank keeps its stored value while the other bank tracks `port_a_i`.
- R8: The slots keep capturing while their port is not driven. When the port is enabled again, it shows the value captured during the disabled period.
- R9: A rising edge with `rst_n` low clears all four slots to zero, so every closed slot then reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; slots capture on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| port_a_i | input | W | Data arriving on A, headed for the banks |
| bank1_i | input | W | Data arriving on bank 1, headed for A |
| bank2_i | input | W | Data arriving on bank 2, headed for A |
| open_b1a_i | input | 1 | Open control of the bank 1 to A slot |
| open_b2a_i | input | 1 | Open control of the bank 2 to A slot |
| open_a2b1_i | input | 1 | Open control of the A to bank 1 slot |
| open_a2b2_i | input | 1 | Open control of the A to bank 2 slot |
| pick_bank1_i | input | 1 | 1 selects bank 1 towards A, 0 selects bank 2 |
| en_a_n_i | input | 1 | Active-low drive enable of A |
| en_b1_n_i | input | 1 | Active-low drive enable of bank 1 |
| en_b2_n_i | input | 1 | Active-low drive enable of bank 2 |
| port_a_o | output | W | Data driven onto A (zero when not driven) |
| port_a_en_o | output | 1 | A is driven |
| bank1_o | output | W | Data driven onto bank 1 (zero when not driven) |
| bank1_en_o | output | 1 | Bank 1 is driven |
| bank2_o | output | W | Data driven onto bank 2 (zero when not driven) |
| bank2_en_o | output | 1 | Bank 2 is driven |

## Verification
The bench builds the block with its default width of 12. At that width, the all-ones, alternating and byte-skewed patterns such as A5A and 0F0 show a dropped or swapped bit in any lane. The vector walk covers every row of both direction tables: transparent, holding and undriven states, each select value and each enable pairing. Directed steps then check the reset clear and the capture of new data while a port is not driven.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_B1A  = 0;
    localparam int SLOT_B2A  = 1;
    localparam int SLOT_A2B1 = 2;
    localparam int SLOT_A2B2 = 3;
endpackage

// File: rtl/mbl_slot.sv
module mbl_slot #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] held;
    } slot_st_t;

    slot_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!rst_n)
            s_d.held = '0;
        else if (open_i)
            s_d.held = d_i;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // level-sensitive view: live input while open, stored value while closed
    assign q_o = open_i ? d_i : s_q.held;
endmodule

// File: rtl/mbl_drive.sv
module mbl_drive #(
    parameter int W = 12
) (
    input  logic [W-1:0] val_i,
    input  logic         en_n_i,
    output logic [W-1:0] val_o,
    output logic         en_o
);
    assign en_o  = !en_n_i;
    assign val_o = en_n_i ? '0 : val_i;
endmodule

// File: rtl/mbl_top.sv
module mbl_top #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port_a_i,
    input  logic [W-1:0] bank1_i,
    input  logic [W-1:0] bank2_i,
    input  logic         open_b1a_i,
    input  logic         open_b2a_i,
    input  logic         open_a2b1_i,
    input  logic         open_a2b2_i,
    input  logic         pick_bank1_i,
    input  logic         en_a_n_i,
    input  logic         en_b1_n_i,
    input  logic         en_b2_n_i,
    output logic [W-1:0] port_a_o,
    output logic         port_a_en_o,
    output logic [W-1:0] bank1_o,
    output logic         bank1_en_o,
    output logic [W-1:0] bank2_o,
    output logic         bank2_en_o
);
    import mbl_pkg::*;

    logic [W-1:0] slot_in   [NUM_SLOTS];
    logic [W-1:0] slot_q    [NUM_SLOTS];
    logic         slot_open [NUM_SLOTS];
    logic [W-1:0] a_pick;

    assign slot_in[SLOT_B1A]    = bank1_i;
    assign slot_in[SLOT_B2A]    = bank2_i;
    assign slot_in[SLOT_A2B1]   = port_a_i;
    assign slot_in[SLOT_A2B2]   = port_a_i;
    assign slot_open[SLOT_B1A]  = open_b1a_i;
    assign slot_open[SLOT_B2A]  = open_b2a_i;
    assign slot_open[SLOT_A2B1] = open_a2b1_i;
    assign slot_open[SLOT_A2B2] = open_a2b2_i;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        mbl_slot #(.W(W)) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .open_i (slot_open[g]),
            .d_i    (slot_in[g]),
            .q_o    (slot_q[g])
        );
    end

    // bank-to-A merge
    assign a_pick = pick_bank1_i ? slot_q[SLOT_B1A] : slot_q[SLOT_B2A];

    mbl_drive #(.W(W)) i_drv_a (
        .val_i (a_pick),
        .en_n_i(en_a_n_i),
        .val_o (port_a_o),
        .en_o  (port_a_en_o)
    );

    mbl_drive #(.W(W)) i_drv_b1 (
        .val_i (slot_q[SLOT_A2B1]),
        .en_n_i(en_b1_n_i),
        .val_o (bank1_o),
        .en_o  (bank1_en_o)
    );

    mbl_drive #(.W(W)) i_drv_b2 (
        .val_i (slot_q[SLOT_A2B2]),
        .en_n_i(en_b2_n_i),
        .val_o (bank2_o),
        .en_o  (bank2_en_o)
    );
endmodule

// File: rtl/mbl_chk.sv
module mbl_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] port_a_i,
    input logic [W-1:0] bank1_i,
    input logic [W-1:0] bank2_i,
    input logic         open_b1a_i,
    input logic         open_b2a_i,
    input logic         open_a2b1_i,
    input logic         open_a2b2_i,
    input logic         pick_bank1_i,
    input logic         en_a_n_i,
    input logic         en_b1_n_i,
    input logic         en_b2_n_i,
    input logic [W-1:0] port_a_o,
    input logic         port_a_en_o,
    input logic [W-1:0] bank1_o,
    input logic         bank1_en_o,
    input logic [W-1:0] bank2_o,
    input logic         bank2_en_o
);
    a_r1_live_bank1: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_bank1_i && open_b1a_i && !en_a_n_i) |-> (port_a_o == bank1_i));

    a_r3_route_bank2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pick_bank1_i && open_b2a_i && !en_a_n_i) |-> (port_a_o == bank2_i));

    a_r2_hold_bank1: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_bank1_i && !open_b1a_i && !en_a_n_i) |=>
        ((pick_bank1_i && !open_b1a_i && !en_a_n_i) |-> $stable(port_a_o)));

    a_r4_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        en_a_n_i |-> (!port_a_en_o && port_a_o == '0));

    a_r5_b1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        en_b1_n_i |-> (!bank1_en_o && bank1_o == '0));

    a_r5_b2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        en_b2_n_i |-> (!bank2_en_o && bank2_o == '0));

    a_r6_both_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (open_a2b1_i && open_a2b2_i && !en_b1_n_i && !en_b2_n_i) |->
        (bank1_o == port_a_i && bank2_o == port_a_i));

    a_r7_bank1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_a2b1_i && !en_b1_n_i) |=>
        ((!open_a2b1_i && !en_b1_n_i) |-> $stable(bank1_o)));

    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !open_a2b1_i && !en_b1_n_i) |-> (bank1_o == '0));
endmodule

bind mbl_top mbl_chk #(.W(W)) i_chk (.*);

// File: tb/test_mbl_top.sv
module test_mbl_top;
    localparam int W = 12;

    typedef struct packed {
        logic [3:0]  op;    // [3] b1->A, [2] b2->A, [1] A->b1, [0] A->b2
        logic [2:0]  en_n;  // [2] A, [1] bank1, [0] bank2
        logic        sel;
        logic [11:0] a;
        logic [11:0] b1;
        logic [11:0] b2;
        logic [12:0] ea;    // {drive, data}
        logic [12:0] eb1;
        logic [12:0] eb2;
        logic [63:0] tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'b1111, 3'b000, 1'b1, 12'hA5A, 12'h123, 12'h456, {1'b1,12'h123}, {1'b1,12'hA5A}, {1'b1,12'hA5A}, "R1 R6"},
        '{4'b1111, 3'b000, 1'b0, 12'hA5A, 12'h123, 12'h456, {1'b1,12'h456}, {1'b1,12'hA5A}, {1'b1,12'hA5A}, "R3"},
        '{4'b0000, 3'b000, 1'b1, 12'hFFF, 12'hFFF, 12'hFFF, {1'b1,12'h123}, {1'b1,12'hA5A}, {1'b1,12'hA5A}, "R2"},
        '{4'b0000, 3'b000, 1'b0, 12'hFFF, 12'hFFF, 12'hFFF, {1'b1,12'h456}, {1'b1,12'hA5A}, {1'b1,12'hA5A}, "R2 R3"},
        '{4'b1000, 3'b000, 1'b1, 12'h0F0, 12'h321, 12'h654, {1'b1,12'h321}, {1'b1,12'hA5A}, {1'b1,12'hA5A}, "R1"},
        '{4'b0010, 3'b000, 1'b0, 12'h0F0, 12'h321, 12'h654, {1'b1,12'h456}, {1'b1,12'h0F0}, {1'b1,12'hA5A}, "R7"},
        '{4'b0001, 3'b000, 1'b1, 12'hC3C, 12'h777, 12'h888, {1'b1,12'h321}, {1'b1,12'h0F0}, {1'b1,12'hC3C}, "R7"},
        '{4'b1111, 3'b100, 1'b1, 12'h111, 12'h222, 12'h333, {1'b0,12'h000}, {1'b1,12'h111}, {1'b1,12'h111}, "R4"},
        '{4'b1111, 3'b010, 1'b0, 12'h444, 12'h555, 12'h666, {1'b1,12'h666}, {1'b0,12'h000}, {1'b1,12'h444}, "R5"},
        '{4'b1111, 3'b001, 1'b1, 12'h777, 12'hABC, 12'h666, {1'b1,12'hABC}, {1'b1,12'h777}, {1'b0,12'h000}, "R5"},
        '{4'b1111, 3'b111, 1'b1, 12'h999, 12'h888, 12'hBBB, {1'b0,12'h000}, {1'b0,12'h000}, {1'b0,12'h000}, "R4 R5"},
        '{4'b0000, 3'b000, 1'b1, 12'h000, 12'h000, 12'h000, {1'b1,12'h888}, {1'b1,12'h999}, {1'b1,12'h999}, "R8"},
        '{4'b0000, 3'b000, 1'b0, 12'h000, 12'h000, 12'h000, {1'b1,12'hBBB}, {1'b1,12'h999}, {1'b1,12'h999}, "R8"}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] port_a_i = '0, bank1_i = '0, bank2_i = '0;
    logic         open_b1a_i = 1'b0, open_b2a_i = 1'b0, open_a2b1_i = 1'b0, open_a2b2_i = 1'b0;
    logic         pick_bank1_i = 1'b1;
    logic         en_a_n_i = 1'b0, en_b1_n_i = 1'b0, en_b2_n_i = 1'b0;
    logic [W-1:0] port_a_o, bank1_o, bank2_o;
    logic         port_a_en_o, bank1_en_o, bank2_en_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    mbl_top #(.W(W)) i_mbl_top (.*);

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        {open_b1a_i, open_b2a_i, open_a2b1_i, open_a2b2_i} = v.op;
        {en_a_n_i, en_b1_n_i, en_b2_n_i} = v.en_n;
        pick_bank1_i = v.sel;
        port_a_i = v.a;
        bank1_i  = v.b1;
        bank2_i  = v.b2;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // reset state, R9
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R9 a after reset", {port_a_en_o, port_a_o}, {1'b1, 12'h000});
        check("R9 bank1 after reset", {bank1_en_o, bank1_o}, {1'b1, 12'h000});
        check("R9 bank2 after reset", {bank2_en_o, bank2_o}, {1'b1, 12'h000});

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("%s vec%0d A", VECS[i].tag, i), {port_a_en_o, port_a_o}, VECS[i].ea);
            check($sformatf("%s vec%0d bank1", VECS[i].tag, i), {bank1_en_o, bank1_o}, VECS[i].eb1);
            check($sformatf("%s vec%0d bank2", VECS[i].tag, i), {bank2_en_o, bank2_o}, VECS[i].eb2);
        end

        // R1: all-ones on A and all-zeros on bank 1, all slots open
        apply('{4'b1111, 3'b000, 1'b1, 12'hFFF, 12'h000, 12'h555,
                13'h0, 13'h0, 13'h0, "R1"});
        check("R1 zeros through A", {port_a_en_o, port_a_o}, {1'b1, 12'h000});
        check("R6 ones to bank1", {bank1_en_o, bank1_o}, {1'b1, 12'hFFF});
        check("R6 ones to bank2", {bank2_en_o, bank2_o}, {1'b1, 12'hFFF});

        // R9: reset after activity, slots closed
        @(negedge clk);
        rst_n = 1'b0;
        {open_b1a_i, open_b2a_i, open_a2b1_i, open_a2b2_i} = 4'b0000;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pick_bank1_i = 1'b1;
        @(posedge clk);
        #1;
        check("R9 bank1 slot cleared", {port_a_en_o, port_a_o}, {1'b1, 12'h000});
        check("R9 A->bank1 cleared", {bank1_en_o, bank1_o}, {1'b1, 12'h000});
        check("R9 A->bank2 cleared", {bank2_en_o, bank2_o}, {1'b1, 12'h000});
        @(negedge clk);
        pick_bank1_i = 1'b0;
        #1;
        check("R9 bank2 slot cleared", {port_a_en_o, port_a_o}, {1'b1, 12'h000});

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule